// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block detects load-use hazards in a five-stage in-order pipeline and requests a single bubble for each one. It compares the two source register numbers of the instruction being decoded against the destination register number of the instruction in the execute stage. If the execute-stage instruction is a memory read and its result is needed by the decoding instruction, three things happen:

- The program counter is frozen.
- The fetch/decode register is frozen.
- The control field captured into the decode/execute register is cleared, so the execute, memory and write-back stages each perform a no-op.

On the following cycle the frozen instruction is decoded again. By then the load has moved into the memory stage, and the forwarding path from the memory/write-back register supplies the loaded value. Dependencies on results that do not come from a load never cause a stall here, because forwarding resolves them.

The unit is purely combinational. Its outputs take effect when the surrounding pipeline registers are next clocked. Because the cleared decode/execute entry carries no memory-read flag, a hazard produces exactly one bubble. Register 0 always reads as zero, so a match on it is never treated as a hazard.

Top module: `loadUseStall`

## Requirements
- R1: When `exMemRead` is 1, `exRt` is non-zero, and `exRt` equals `idRs` or `idRt`, the unit signals a stall in the same cycle. A stall is `pcWriteEn`=0, `ifIdWriteEn`=0 and `idExBubble`=1.
- R2: When `exMemRead` is 0, no stall is signalled, whatever the register fields hold.
- R3: When `exRt` is 0, no stall is signalled, even if `exMemRead` is 1 and a source field is also 0.
- R4: During a stall, `pcWriteEn` is 0, so the next instruction is fetched again.
- R5: During a stall, `ifIdWriteEn` is 0, so the dependent instruction is decoded again.
- R6: During a stall, `idExBubble` is 1, which selects all-zero control values for the decode/execute register. Outside a stall, `idExBubble` is 0.
- R7: When no hazard is present, `pcWriteEn` and `ifIdWriteEn` are both 1.
- R8: A load followed directly by a dependent instruction produces exactly one stall cycle: the second cycle, with a bubble in execute, does not stall. A load followed by an independent instruction produces no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_ADDR_W | First source register number of the instruction in decode |
| idRt | input | REG_ADDR_W | Second source register number of the instruction in decode |
| exRt | input | REG_ADDR_W | Destination register number of the instruction in execute |
| exMemRead | input | 1 | Execute-stage instruction reads data memory |
| pcWriteEn | output | 1 | Program counter update enable (0 holds it) |
| ifIdWriteEn | output | 1 | Fetch/decode register update enable (0 holds it) |
| idExBubble | output | 1 | 1 selects zero control values for the decode/execute register |

## Verification
The checker evaluates immediate assertions only when every port carries a known value. It assumes the pipeline around the unit presents a settled, fully defined set of register fields and memory-read flag. The bench drives all inputs on the falling clock edge from a single process, so no X or Z value reaches the unit after the first drive. It sweeps every combination of the three register fields with the memory-read flag both low and high. After that it replays two short load sequences, feeding in the bubble the unit requested as the next execute-stage state.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Strobes passed from the hazard control logic to the output stage.
  typedef struct packed {
    logic holdFetch;   // freeze PC and fetch/decode register
    logic injectNop;   // clear decode/execute control field
  } stallStrobe_t;

  localparam int NUM_SRC = 2;  // source operands examined per decoded instruction

endpackage

// File: rtl/hazardCompare.sv
module hazardCompare
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter bit ZERO_REG_FIXED = 1'b1
) (
  input  logic [NUM_SRC*REG_ADDR_W-1:0] srcRegs,
  input  logic [REG_ADDR_W-1:0]         loadDst,
  output logic [NUM_SRC-1:0]            srcHit
);

  localparam logic [REG_ADDR_W-1:0] ZERO_ADDR = '0;

  logic dstLive;

  generate
    if (ZERO_REG_FIXED) begin : g_zeroFixed
      assign dstLive = (loadDst != ZERO_ADDR);
    end else begin : g_zeroNormal
      assign dstLive = 1'b1;
    end
  endgenerate

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [REG_ADDR_W-1:0] srcField;
      assign srcField = srcRegs[s*REG_ADDR_W +: REG_ADDR_W];
      assign srcHit[s] = dstLive && (srcField == loadDst);
    end
  endgenerate

endmodule

// File: rtl/hazardCtrl.sv
module hazardCtrl
  import hazard_pkg::*;
(
  input  logic [NUM_SRC-1:0] srcHit,
  input  logic               loadInEx,
  output stallStrobe_t       strobe
);

  logic hazard;

  always_comb begin
    hazard = loadInEx && (|srcHit);
    strobe.holdFetch = hazard;
    strobe.injectNop = hazard;
  end

endmodule

// File: rtl/loadUseStall.sv
module loadUseStall
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] idRs,
  input  logic [REG_ADDR_W-1:0] idRt,
  input  logic [REG_ADDR_W-1:0] exRt,
  input  logic                  exMemRead,
  output logic                  pcWriteEn,
  output logic                  ifIdWriteEn,
  output logic                  idExBubble
);

  logic [NUM_SRC-1:0] srcHit;
  stallStrobe_t       strobe;

  hazardCompare #(
    .REG_ADDR_W(REG_ADDR_W),
    .ZERO_REG_FIXED(1'b1)
  ) u_compare (
    .srcRegs(({idRt, idRs})),
    .loadDst(exRt),
    .srcHit (srcHit)
  );

  hazardCtrl u_ctrl (
    .srcHit  (srcHit),
    .loadInEx(exMemRead),
    .strobe  (strobe)
  );

  assign pcWriteEn   = ~strobe.holdFetch;
  assign ifIdWriteEn = ~strobe.holdFetch;
  assign idExBubble  = strobe.injectNop;

endmodule

// File: rtl/loadUseStallChecker.sv
module loadUseStallChecker #(
  parameter int REG_ADDR_W = 5
) (
  input logic [REG_ADDR_W-1:0] idRs,
  input logic [REG_ADDR_W-1:0] idRt,
  input logic [REG_ADDR_W-1:0] exRt,
  input logic                  exMemRead,
  input logic                  pcWriteEn,
  input logic                  ifIdWriteEn,
  input logic                  idExBubble
);

  logic known;
  logic srcMatch;

  always_comb begin
    known    = !$isunknown({idRs, idRt, exRt, exMemRead, pcWriteEn, ifIdWriteEn, idExBubble});
    srcMatch = (exRt == idRs) || (exRt == idRt);
    if (known) begin
      assert_stall_on_load_use_R1: assert (!(exMemRead && exRt != '0 && srcMatch) || idExBubble)
        else $error("R1: load-use match without bubble");
      assert_no_stall_without_load_R2: assert (exMemRead || (pcWriteEn && !idExBubble))
        else $error("R2: stall without memory read");
      assert_no_stall_on_zero_reg_R3: assert (exRt != '0 || pcWriteEn)
        else $error("R3: stall on register 0");
      assert_fetch_holds_together_R4_R5: assert (pcWriteEn == ifIdWriteEn)
        else $error("R4/R5: PC and IF/ID enables disagree");
      assert_bubble_matches_hold_R6: assert (idExBubble == !ifIdWriteEn)
        else $error("R6: bubble select disagrees with hold");
      assert_run_when_clear_R7: assert (srcMatch || pcWriteEn)
        else $error("R7: stall with no register match");
    end
  end

endmodule

bind loadUseStall loadUseStallChecker #(.REG_ADDR_W(REG_ADDR_W)) u_checker (
  .idRs       (idRs),
  .idRt       (idRt),
  .exRt       (exRt),
  .exMemRead  (exMemRead),
  .pcWriteEn  (pcWriteEn),
  .ifIdWriteEn(ifIdWriteEn),
  .idExBubble (idExBubble)
);

// File: tb/loadUseStall_test.sv
`timescale 1ns/1ps
module loadUseStall_test;

  localparam int W = 5;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] idRs, idRt, exRt;
  logic         exMemRead;
  logic         pcWriteEn, ifIdWriteEn, idExBubble;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  loadUseStall #(.REG_ADDR_W(W)) uut (
    .idRs(idRs), .idRt(idRt), .exRt(exRt), .exMemRead(exMemRead),
    .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn), .idExBubble(idExBubble)
  );

  task automatic expectOut(input string req, input bit stall);
    logic [2:0] got, want;
    got  = {pcWriteEn, ifIdWriteEn, idExBubble};
    want = stall ? 3'b001 : 3'b110;
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s: rs=%0d rt=%0d exRt=%0d rd=%0b got pc/ifid/bub=%b expected %b",
               req, idRs, idRt, exRt, exMemRead, got, want);
    end
  endtask

  task automatic apply(input int rs, input int rt, input int ex, input bit rd);
    @(negedge clk);
    idRs = W'(rs); idRt = W'(rt); exRt = W'(ex); exMemRead = rd;
    #1;
  endtask

  int stallCount;
  bit curRd;
  int curEx;

  initial begin
    idRs = '0; idRt = '0; exRt = '0; exMemRead = 1'b0;
    // reset / idle state: nothing in execute reads memory
    apply(0, 0, 0, 0);
    expectOut("R7 idle", 1'b0);

    // Exhaustive sweep of all field combinations, both flag values
    for (int rd = 0; rd < 2; rd++) begin
      for (int ex = 0; ex < N; ex++) begin
        for (int rs = 0; rs < N; rs++) begin
          for (int rt = 0; rt < N; rt++) begin
            bit exp;
            string tag;
            exp = (rd == 1) && (ex != 0) && ((ex == rs) || (ex == rt));
            if (rd == 0)      tag = "R2 no load";
            else if (ex == 0) tag = "R3 zero reg";
            else if (exp)     tag = "R1 R4 R5 R6 stall";
            else              tag = "R7 no match";
            apply(rs, rt, ex, rd[0]);
            expectOut(tag, exp);
          end
        end
      end
    end

    // R8: load to r2, then dependent "and r12, r2, r5"
    stallCount = 0; curRd = 1'b1; curEx = 2;
    for (int c = 0; c < 3; c++) begin
      apply(2, 5, curEx, curRd);
      if (idExBubble === 1'b1) stallCount++;
      // next cycle: bubble (no read) in EX if stalled, else the AND moved on
      if (idExBubble === 1'b1) begin curRd = 1'b0; curEx = 0; end
      else begin curRd = 1'b0; curEx = 12; end
    end
    checks++;
    if (stallCount != 1) begin
      failures++;
      $display("FAIL R8 dependent: stall cycles got %0d expected 1", stallCount);
    end

    // R8: load to r2, then independent "and r12, r6, r7"
    stallCount = 0;
    apply(6, 7, 2, 1'b1);
    if (idExBubble === 1'b1) stallCount++;
    apply(6, 7, 12, 1'b0);
    if (idExBubble === 1'b1) stallCount++;
    checks++;
    if (stallCount != 0) begin
      failures++;
      $display("FAIL R8 independent: stall cycles got %0d expected 0", stallCount);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule